// File: doc/BRIEF.md
# Byte Memory Parity Guard with Failing-Bank Capture

This block sits next to a byte-wide memory built from several banks and adds one stored check bit per byte. During a write it produces the check bit from the data bus, so that the eight data bits and the check bit together hold an odd number of ones. The memory stores that bit alongside the byte.

During a read, the block takes the returned byte and the stored check bit from the final cycle of the read strobe. When the strobe ends, it tests their combined parity. If the nine bits hold an even number of ones, the block records the bank-select lines that were active in that final cycle and lights the matching error indicators. It also raises a halt request to the processor.

Only the first failure is recorded. The indicators and the halt stay fixed until a clear or a reset. Cycles in which the write strobe is high are never checked, because during a write the stored check bit is not being driven back.

Top module: `mem_parity_guard`

## Requirements
- R1: `par_wr` is 1 exactly when `data` holds an even number of ones, so that `{data, par_wr}` always has odd parity.
- R2: A read whose final-cycle `{data, par_rd}` has odd parity leaves `halt` low and `err_led` all zero.
- R3: A read whose final-cycle `{data, par_rd}` has even parity sets `halt` and loads `err_led` with the `bank_sel` value (bit i = bank i, active high) of that cycle. Both become visible after the first rising clock edge at which `rd_stb` is sampled low following a high sample.
- R4: Only the last cycle of a multi-cycle read strobe is checked; data and check bit in earlier cycles of the same strobe have no effect.
- R5: A cycle in which `wr_stb` is high is not checked, even when `rd_stb` is also high.
- R6: While `halt` is high, a further failing read leaves `err_led` unchanged.
- R7: `halt` and `err_led` hold until `err_clr` is sampled high, which clears both at that edge. A failing read that completes at the same edge as the clear is discarded.
- R8: While `rst_n` is low (asynchronous, active low), `halt` is 0 and `err_led` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| data | input | DATA_W | Memory data byte |
| bank_sel | input | NUM_BANKS | Bank (row) select strobes, active high |
| par_wr | output | 1 | Check bit to store on a write |
| par_rd | input | 1 | Stored check bit returned on a read |
| err_clr | input | 1 | Clears the captured error and the halt |
| err_led | output | NUM_BANKS | Per-bank error indicators |
| halt | output | 1 | Halt request to the processor |

## Verification
The bench corrupts stored check bits in chosen banks. It then checks that the captured bank is the one selected in the last read cycle, and not an earlier or later one. A design that checked the first cycle of a long strobe would halt on transient bad data, or would miss a bad final beat. A design that kept re-latching would overwrite the first failing bank with a later one. The bench also overlaps the read and write strobes, to catch a checker that reports errors during writes. Finally, it lands a failing read on the same edge as a clear, to catch a design that lets the error win over the clear.

// File: rtl/mem_parity_guard.sv
module mem_parity_guard #(
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic                 rd_stb,
  input  logic [DATA_W-1:0]    data,
  input  logic [NUM_BANKS-1:0] bank_sel,
  output logic                 par_wr,
  input  logic                 par_rd,
  input  logic                 err_clr,
  output logic [NUM_BANKS-1:0] err_led,
  output logic                 halt
);

  logic                 rd_live;
  logic                 cap_odd;
  logic [NUM_BANKS-1:0] cap_bank;
  logic                 rd_end;
  logic                 fail;

  assign par_wr = ~^data;
  assign rd_end = rd_live & ~(rd_stb & ~wr_stb);
  assign fail   = rd_end & ~cap_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_live  <= 1'b0;
      cap_odd  <= 1'b1;
      cap_bank <= '0;
    end else begin
      rd_live <= rd_stb & ~wr_stb;
      if (rd_stb && !wr_stb) begin
        cap_odd  <= ^{data, par_rd};
        cap_bank <= bank_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt    <= 1'b0;
      err_led <= '0;
    end else if (err_clr) begin
      halt    <= 1'b0;
      err_led <= '0;
    end else if (fail && !halt) begin
      halt    <= 1'b1;
      err_led <= cap_bank;
    end
  end

endmodule

module mem_parity_guard_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rd_stb,
  input logic [NUM_BANKS-1:0] bank_sel,
  input logic                 err_clr,
  input logic [NUM_BANKS-1:0] err_led,
  input logic                 halt
);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !err_clr |=> halt);

  p_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !err_clr |=> $stable(err_led));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !halt && err_led == '0);

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !halt && !rd_stb && !$past(rd_stb) |=> !halt);

  p_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> err_led == $past(bank_sel, 2));

endmodule

bind mem_parity_guard mem_parity_guard_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .bank_sel(bank_sel),
  .err_clr(err_clr), .err_led(err_led), .halt(halt)
);

// File: tb/mem_parity_guard_tb_top.sv
module mem_parity_guard_tb_top;
  localparam int DW = 8;
  localparam int NB = 4;
  localparam int NV = 8;
  localparam logic [8:0] VEC [NV] = '{
    {8'h00,1'b1}, {8'h01,1'b0}, {8'hFF,1'b1}, {8'h7F,1'b0},
    {8'hA5,1'b1}, {8'h80,1'b0}, {8'h03,1'b1}, {8'hAB,1'b0}};

  logic clk = 0, rst_n = 0, wr_stb = 0, rd_stb = 0, par_rd = 0, err_clr = 0;
  logic [DW-1:0] data = '0;
  logic [NB-1:0] bank_sel = '0;
  logic par_wr, halt;
  logic [NB-1:0] err_led;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] mem [NB][4];
  logic          pbit [NB][4];

  always #4 clk = ~clk;

  mem_parity_guard #(.DATA_W(DW), .NUM_BANKS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .data(data),
    .bank_sel(bank_sel), .par_wr(par_wr), .par_rd(par_rd), .err_clr(err_clr),
    .err_led(err_led), .halt(halt));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic odd_bit(input logic [DW-1:0] d);
    int n = 0;
    for (int i = 0; i < DW; i++) n += d[i];
    return (n % 2 == 0);
  endfunction

  task automatic do_write(input int b, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_stb = 1; data = d; bank_sel = NB'(1 << b);
    #1 mem[b][a] = d; pbit[b][a] = par_wr;
    @(negedge clk);
    wr_stb = 0; bank_sel = '0;
  endtask

  // read with a first beat (d0,p0) and a last beat (d1,p1); nbeats >= 1
  task automatic do_read2(input int b, input logic [DW-1:0] d0, input logic p0,
                          input logic [DW-1:0] d1, input logic p1, input int nbeats,
                          input logic clr_at_end);
    for (int k = 0; k < nbeats; k++) begin
      @(negedge clk);
      rd_stb = 1; bank_sel = NB'(1 << b);
      if (k == nbeats - 1) begin data = d1; par_rd = p1; end
      else begin data = d0; par_rd = p0; end
    end
    @(negedge clk);
    rd_stb = 0; bank_sel = '0; err_clr = clr_at_end;
    @(negedge clk);
    err_clr = 0;
  endtask

  task automatic do_read(input int b, input int a);
    do_read2(b, mem[b][a], pbit[b][a], mem[b][a], pbit[b][a], 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(halt == 0 && err_led == 0, "R8 reset", {err_led, halt}, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_stb = 1; data = VEC[i][8:1];
      #1 chk(par_wr == VEC[i][0], "R1 parity vector", par_wr, VEC[i][0]);
    end
    @(negedge clk); wr_stb = 0;

    for (int b = 0; b < NB; b++)
      for (int a = 0; a < 4; a++) do_write(b, a, DW'(b * 37 + a * 11 + 5));
    chk(pbit[2][3] == odd_bit(mem[2][3]), "R1 stored bit", pbit[2][3], odd_bit(mem[2][3]));
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < 4; a++) do_read(b, a);
    chk(halt == 0 && err_led == 0, "R2 clean reads", {err_led, halt}, 0);

    pbit[2][1] = ~pbit[2][1];
    do_read(2, 1);
    chk(halt == 1, "R3 halt on bad read", halt, 1);
    chk(err_led == 4'b0100, "R3 bank captured", err_led, 4'b0100);

    pbit[1][0] = ~pbit[1][0];
    do_read(1, 0);
    chk(err_led == 4'b0100, "R6 first error kept", err_led, 4'b0100);
    repeat (5) @(negedge clk);
    chk(halt == 1, "R7 halt holds", halt, 1);

    err_clr = 1; @(negedge clk); err_clr = 0;
    chk(halt == 0 && err_led == 0, "R7 clear", {err_led, halt}, 0);

    do_read2(3, 8'h00, 1'b0, 8'h00, 1'b1, 3, 0);
    chk(halt == 0, "R4 bad early beat ignored", halt, 0);
    do_read2(3, 8'h00, 1'b1, 8'h01, 1'b1, 3, 0);
    chk(halt == 1 && err_led == 4'b1000, "R4 bad last beat", {err_led, halt}, 5'b10001);
    err_clr = 1; @(negedge clk); err_clr = 0;

    @(negedge clk);
    rd_stb = 1; wr_stb = 1; bank_sel = 4'b0001; data = 8'h00; par_rd = 0;
    @(negedge clk);
    rd_stb = 0; wr_stb = 0; bank_sel = '0;
    repeat (2) @(negedge clk);
    chk(halt == 0 && err_led == 0, "R5 write cycle not checked", {err_led, halt}, 0);

    do_read2(0, 8'h00, 1'b0, 8'h00, 1'b0, 1, 1);
    chk(halt == 0 && err_led == 0, "R7 clear wins", {err_led, halt}, 0);
    @(negedge clk);
    chk(halt == 0, "R7 no late error", halt, 0);

    do_read2(1, 8'h00, 1'b0, 8'h00, 1'b0, 1, 0);
    chk(halt == 1 && err_led == 4'b0010, "R3 bank1", {err_led, halt}, 5'b00101);
    rst_n = 0; #1;
    chk(halt == 0 && err_led == 0, "R8 async reset", {err_led, halt}, 0);
    @(negedge clk); rst_n = 1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule